// File: doc/BRIEF.md
# Interval Routing Output Selector

This block makes the output decision for one input of a wormhole packet switch. The destination number from a packet's header is compared at the same time against a table of programmable routing entries. Each entry is a half-open range of destinations, and each entry owns a bundle of equivalent output links given as a bit mask. The entry whose range holds the destination names the bundle. The block then grants the lowest-numbered member of that bundle that is not busy at that moment.

Once granted, the route stays fixed for the rest of the packet. The flits that follow the header need no further decision. The route is released after the end-of-packet token has been seen. A destination that falls in no range raises an error flag, and the packet is steered to a programmable discard link. When the ranges are programmed with disjoint bundles, separate groups of destinations use separate groups of links. This partitions the network into independent subnetworks.

Top module: `interval_route_sel`

## Requirements
- R1: While reset is held and in the first cycle after it is released, routeOpen, grantValid and missErr are 0 and grantLink is 0. After reset every entry has lower bound 0, upper bound 0 and mask 0, and the discard link is 0.
- R2: Entry i matches destination d when lo[i] <= d < hi[i]. The upper bound is exclusive, and an entry with lo >= hi matches nothing. If several entries match, the lowest-indexed one is used. A header is accepted when hdrValid is 1 while no route is pending or open.
- R3: Let a header be accepted at clock edge E, and let the chosen bundle have a free link (linkBusy bit 0) at edge E+1. Then grantValid is 1 for exactly the one cycle after E+1. grantLink then shows the lowest-numbered link that is both set in the bundle mask and free.
- R4: If no member of the bundle is free, the request waits. On the first edge at which a member is free, the grant is issued. The block never waits while a member is free.
- R5: While routeOpen is 1, grantLink does not change. hdrValid is ignored, and configuration writes do not alter the open route.
- R6: routeOpen rises together with grantValid. routeOpen falls after the edge that samples eopValid = 1 while the route is open. A header presented after that is accepted normally.
- R7: If no entry matches, missErr is 1 from the cycle after the header is accepted until the route closes. The bundle used is the single discard link.
- R8: The configuration write port works as follows. When cfgWe is 1 at an edge, cfgSel selects what entry cfgIdx receives: cfgSel 0 writes the lower bound from cfgData[15:0], 1 writes the upper bound from cfgData[15:0], and 2 writes the bundle mask from cfgData[31:0]. cfgSel 3 writes the discard link from cfgData[4:0]. A write takes effect for headers accepted at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hdrValid | input | 1 | Header flit present with a destination |
| hdrDest | input | 16 | Destination number from the header |
| eopValid | input | 1 | End-of-packet token passing on the open route |
| linkBusy | input | 32 | Per-link busy flags, 1 means occupied |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | 3 | Routing entry written |
| cfgSel | input | 2 | Field selected: lower, upper, mask, discard |
| cfgData | input | 32 | Configuration write data |
| grantValid | output | 1 | One-cycle pulse when a route is granted |
| grantLink | output | 5 | Output link of the current route |
| routeOpen | output | 1 | A route is held for the current packet |
| missErr | output | 1 | Current packet matched no routing entry |

## Verification
A stale or wrong captured bundle mask shows up in the grant pulse itself, two edges after the header: either the wrong link index or a grant to a link that was busy. A control state stuck in the waiting phase shows as a missing grantValid on the first cycle after a bundle member frees. Its mirror image is a route that fails to drop, which keeps routeOpen high one cycle past the end token. Both are visible within one cycle of the event. The reference model tracks every cycle, so any divergence in the four outputs is reported in the cycle it occurs.

// File: rtl/ivlr_pkg.sv
package ivlr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_OPEN = 2'd2
  } rtState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capture;
    logic issue;
    logic close;
  } ctrlStrobe_t;

  localparam logic [1:0] CFG_LO   = 2'd0;
  localparam logic [1:0] CFG_HI   = 2'd1;
  localparam logic [1:0] CFG_MASK = 2'd2;
  localparam logic [1:0] CFG_DISC = 2'd3;
endpackage

// File: rtl/ivlr_match.sv
module ivlr_match import ivlr_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int DEST_W  = 16,
  parameter int LINKS   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINK_W = $clog2(LINKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [1:0]        cfgSel,
  input  logic [LINKS-1:0]  cfgData,
  input  logic [DEST_W-1:0] dest,
  output logic [LINKS-1:0]  selMask,
  output logic              miss
);
  logic [DEST_W-1:0] loQ   [ENTRIES];
  logic [DEST_W-1:0] hiQ   [ENTRIES];
  logic [LINKS-1:0]  maskQ [ENTRIES];
  logic [LINK_W-1:0] discQ;
  logic [ENTRIES-1:0] hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discQ <= '0;
    end else if (cfgWe && cfgSel == CFG_DISC) begin
      discQ <= cfgData[LINK_W-1:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gEntry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          loQ[g]   <= '0;
          hiQ[g]   <= '0;
          maskQ[g] <= '0;
        end else if (cfgWe && cfgIdx == IDX_W'(g)) begin
          case (cfgSel)
            CFG_LO:   loQ[g]   <= cfgData[DEST_W-1:0];
            CFG_HI:   hiQ[g]   <= cfgData[DEST_W-1:0];
            CFG_MASK: maskQ[g] <= cfgData;
            default:  ;
          endcase
        end
      end
      assign hitVec[g] = (loQ[g] <= dest) && (dest < hiQ[g]);
    end
  endgenerate

  always_comb begin
    selMask = '0;
    selMask[discQ] = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) selMask = maskQ[i];
    end
    miss = ~|hitVec;
  end
endmodule

// File: rtl/ivlr_pick.sv
module ivlr_pick #(
  parameter int LINKS   = 32,
  localparam int LINK_W = $clog2(LINKS)
) (
  input  logic [LINKS-1:0]  cand,
  output logic              anyFree,
  output logic [LINK_W-1:0] pickIdx
);
  always_comb begin
    pickIdx = '0;
    for (int i = LINKS - 1; i >= 0; i--) begin
      if (cand[i]) pickIdx = LINK_W'(i);
    end
  end
  assign anyFree = |cand;
endmodule

// File: rtl/ivlr_datapath.sv
module ivlr_datapath import ivlr_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int DEST_W  = 16,
  parameter int LINKS   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINK_W = $clog2(LINKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DEST_W-1:0] hdrDest,
  input  logic [LINKS-1:0]  linkBusy,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [1:0]        cfgSel,
  input  logic [LINKS-1:0]  cfgData,
  output logic              anyFree,
  output logic              grantValid,
  output logic [LINK_W-1:0] grantLink,
  output logic              missErr
);
  logic [LINKS-1:0]  selMask;
  logic              miss;
  logic [LINKS-1:0]  reqMask;
  logic [LINK_W-1:0] pickIdx;

  ivlr_match #(.ENTRIES(ENTRIES), .DEST_W(DEST_W), .LINKS(LINKS)) uMatch (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgSel(cfgSel),
    .cfgData(cfgData), .dest(hdrDest), .selMask(selMask), .miss(miss)
  );

  ivlr_pick #(.LINKS(LINKS)) uPick (
    .cand(reqMask & ~linkBusy), .anyFree(anyFree), .pickIdx(pickIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqMask    <= '0;
      missErr    <= 1'b0;
      grantLink  <= '0;
      grantValid <= 1'b0;
    end else begin
      grantValid <= strobe.issue;
      if (strobe.capture) begin
        reqMask <= selMask;
        missErr <= miss;
      end else if (strobe.close) begin
        missErr <= 1'b0;
      end
      if (strobe.issue) grantLink <= pickIdx;
    end
  end

  assert_bundle_member_R3: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> reqMask[grantLink]);

  assert_miss_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    missErr |-> ($countones(reqMask) == 1));
endmodule

// File: rtl/ivlr_ctrl.sv
module ivlr_ctrl import ivlr_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hdrValid,
  input  logic        eopValid,
  input  logic        anyFree,
  output ctrlStrobe_t strobe,
  output logic        routeOpen
);
  rtState_t state;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && hdrValid;
    strobe.issue   = (state == ST_ARB) && anyFree;
    strobe.close   = (state == ST_OPEN) && eopValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (hdrValid) state <= ST_ARB;
        ST_ARB:  if (anyFree)  state <= ST_OPEN;
        ST_OPEN: if (eopValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign routeOpen = (state == ST_OPEN);

  assert_no_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARB && anyFree) |=> routeOpen);

  assert_close_route_R6: assert property (@(posedge clk) disable iff (!rstN)
    (routeOpen && eopValid) |=> (state == ST_IDLE));
endmodule

// File: rtl/interval_route_sel.sv
module interval_route_sel import ivlr_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int DEST_W  = 16,
  parameter int LINKS   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINK_W = $clog2(LINKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic [DEST_W-1:0] hdrDest,
  input  logic              eopValid,
  input  logic [LINKS-1:0]  linkBusy,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [1:0]        cfgSel,
  input  logic [LINKS-1:0]  cfgData,
  output logic              grantValid,
  output logic [LINK_W-1:0] grantLink,
  output logic              routeOpen,
  output logic              missErr
);
  ctrlStrobe_t strobe;
  logic        anyFree;

  ivlr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .eopValid(eopValid),
    .anyFree(anyFree), .strobe(strobe), .routeOpen(routeOpen)
  );

  ivlr_datapath #(.ENTRIES(ENTRIES), .DEST_W(DEST_W), .LINKS(LINKS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hdrDest(hdrDest),
    .linkBusy(linkBusy), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgSel(cfgSel),
    .cfgData(cfgData), .anyFree(anyFree), .grantValid(grantValid),
    .grantLink(grantLink), .missErr(missErr)
  );

  assert_hold_link_R5: assert property (@(posedge clk) disable iff (!rstN)
    (routeOpen && $past(routeOpen)) |-> $stable(grantLink));

  assert_grant_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !grantValid);

  assert_grant_opens_R6: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> routeOpen);
endmodule

// File: tb/sim_interval_route_sel.sv
module sim_interval_route_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int NL = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hdrValid = 1'b0;
  logic [15:0] hdrDest = '0;
  logic        eopValid = 1'b0;
  logic [31:0] linkBusy = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgIdx = '0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic        grantValid;
  logic [4:0]  grantLink;
  logic        routeOpen;
  logic        missErr;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";
  bit done = 1'b0;

  interval_route_sel u0 (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrDest(hdrDest),
    .eopValid(eopValid), .linkBusy(linkBusy), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgSel(cfgSel), .cfgData(cfgData), .grantValid(grantValid),
    .grantLink(grantLink), .routeOpen(routeOpen), .missErr(missErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  int mLo [NE];
  int mHi [NE];
  bit [31:0] mMask [NE];
  int mDisc = 0;
  int mState = 0;
  bit [31:0] mReq = '0;
  bit mMiss = 1'b0;
  bit mGv = 1'b0;
  int mLink = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NE; i++) begin mLo[i] = 0; mHi[i] = 0; mMask[i] = '0; end
      mDisc = 0; mState = 0; mReq = '0; mMiss = 1'b0; mGv = 1'b0; mLink = 0;
    end else begin
      bit found;
      bit [31:0] freeSet;
      mGv = 1'b0;
      case (mState)
        0: if (hdrValid) begin
          found = 1'b0;
          for (int i = 0; i < NE; i++) begin
            if (!found && mLo[i] <= int'(hdrDest) && int'(hdrDest) < mHi[i]) begin
              found = 1'b1; mReq = mMask[i];
            end
          end
          if (!found) begin mReq = '0; mReq[mDisc] = 1'b1; end
          mMiss = !found;
          mState = 1;
        end
        1: begin
          freeSet = mReq & ~linkBusy;
          if (freeSet != 0) begin
            for (int i = NL - 1; i >= 0; i--) if (freeSet[i]) mLink = i;
            mGv = 1'b1;
            mState = 2;
          end
        end
        default: if (eopValid) begin mState = 0; mMiss = 1'b0; end
      endcase
      if (cfgWe) begin
        case (cfgSel)
          2'd0: mLo[cfgIdx] = int'(cfgData[15:0]);
          2'd1: mHi[cfgIdx] = int'(cfgData[15:0]);
          2'd2: mMask[cfgIdx] = cfgData;
          default: mDisc = int'(cfgData[4:0]);
        endcase
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", curTag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("routeOpen", int'(routeOpen), int'(mState == 2));
      chk("grantValid", int'(grantValid), int'(mGv));
      chk("missErr", int'(missErr), int'(mMiss));
      chk("grantLink", int'(grantLink), mLink);
    end
  end

  task automatic cfg(input int idx, input int sel, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 3'(idx); cfgSel = 2'(sel); cfgData = 32'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic entry(input int idx, input int lo, input int hi, input int mask);
    cfg(idx, 0, lo); cfg(idx, 1, hi); cfg(idx, 2, mask);
  endtask

  task automatic sendHdr(input int d);
    @(negedge clk);
    hdrValid = 1'b1; hdrDest = 16'(d);
    @(negedge clk);
    hdrValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic endPkt();
    @(negedge clk);
    eopValid = 1'b1;
    @(negedge clk);
    eopValid = 1'b0;
  endtask

  task automatic packet(input string tag, input int d, input int expLink);
    curTag = tag;
    sendHdr(d);
    idle(2);
    chk("route link", int'(grantLink), expLink);
    idle(2);
    endPkt();
    idle(1);
  endtask

  initial begin
    curTag = "R1";
    idle(3);
    rstN = 1'b1;
    idle(2);
    curTag = "R8";
    entry(0, 0, 100, 32'h0000_000F);
    entry(1, 100, 200, 32'h0000_00F0);
    entry(2, 200, 300, 32'h0001_0000);
    entry(3, 500, 500, 32'h0000_0100);
    entry(4, 400, 600, 32'h0000_0200);
    cfg(0, 3, 31);
    packet("R3", 50, 0);
    linkBusy = 32'h0000_0030;
    packet("R3", 150, 6);
    linkBusy = 32'h0001_0000;
    curTag = "R4";
    sendHdr(250);
    idle(5);
    chk("waiting no route", int'(routeOpen), 0);
    linkBusy = '0;
    idle(3);
    chk("late route link", int'(grantLink), 16);
    endPkt();
    packet("R2", 500, 9);
    packet("R7", 700, 31);
    curTag = "R5";
    sendHdr(120);
    idle(2);
    hdrValid = 1'b1; hdrDest = 16'd50;
    cfg(1, 2, 32'h0000_0001);
    hdrValid = 1'b0;
    idle(2);
    chk("held link", int'(grantLink), 4);
    endPkt();
    packet("R8", 130, 0);
    cfg(5, 0, 0); cfg(5, 1, 50); cfg(5, 2, 32'h0000_0400);
    packet("R2", 20, 0);
    packet("R2", 99, 0);
    packet("R2", 100, 0);
    packet("R2", 300, 31);
    curTag = "R6";
    sendHdr(10);
    idle(2);
    endPkt();
    sendHdr(250);
    idle(3);
    chk("reopen", int'(routeOpen), 1);
    endPkt();
    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", curTag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule